// File: doc/BRIEF.md
# Per-Core Performance State Controller

This block keeps the committed performance state of each processor core and moves a core to a new state only after a programmable settling delay. Seven states are defined, numbered 0 to 6. States 0 to 4 are the normal operating points and states 5 and 6 are turbo points. Each state owns a small frequency-code register that software fills in to describe that operating point.

Software asks a core for a new state by writing the state number into that core's request register. A separate address space holds these request registers, so writing one never touches the configuration. The controller keeps the old state for a lock delay and then commits the requested one. The delay is a count with either a fine unit (one clock) or a coarse unit (128 clocks), and both are set in a timing register.

All cores report their committed state through one packed status word. A core that leaves its low-power mode signals a wake pulse. The core then returns in state 0, any transition it had pending is dropped, and it stays in state 0 until software writes a new request.

Top module: `pstate_ctrl`

## Requirements
- R1: After reset every core reports state 0, every frequency code is 0, the lock count is 0, the coarse flag is clear, and the read data is 0.
- R2: In the configuration space (bus_space=0), the register for state s (0 to 6, turbo states included) sits at offset 0x100 + s*0x10. Bits 5:0 are a read/write frequency code, and bits 31:6 read as 0.
- R3: In the configuration space, offset 0x440 holds the lock count in bits 7:0 and the coarse flag in bit 31. Its other bits read as 0. Read data appears on bus_rdata on the clock edge that accepts the read and holds until the next read.
- R4: Configuration offset 0x000 is a read-only status word. Core c's state sits in bits 4c+2:4c and all other bits are 0. Writes to it have no effect.
- R5: A request written with bus_space=1 to offset 0x100 + c*0x1000 and holding a value from 0 to 6 is committed exactly D clock edges after the edge that accepts it. Until then the core shows its old state. D = lock count × (128 if coarse, else 1), or D = 1 when that product is 0, and D is taken from the timing register at the moment of acceptance.
- R6: A request value above 6 (the whole 32-bit word compared) is ignored. The core's state and any pending transition are left unchanged.
- R7: A legal request that arrives while a transition is pending cancels that transition. The new target is committed D edges after the new request.
- R8: A one-cycle wake pulse on core_wake[c] sets core c to state 0 on that edge and cancels its pending transition. A legal request accepted on the same edge still starts a new transition.
- R9: Reads of the request space and of unmapped configuration offsets return 0. Writes to unmapped offsets change nothing.
- R10: Cores are independent. A request or wake for one core never changes another core's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_space | input | 1 | 0 = configuration space, 1 = request space |
| bus_addr | input | ADDR_W (16) | Byte offset within the selected space |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| core_wake | input | NUM_CORES (2) | Per-core pulse: core has left its low-power mode |
| core_state | output | 3*NUM_CORES (6) | Committed state of each core, core c in bits 3c+2:3c |

## Verification
A countdown that is wrong by one cycle shows up as core_state changing one edge early or late, which is exactly the edge a timing check compares. A target latched at the wrong time, or a pending flag that survives a wake, shows up as a state change that nothing asked for, tens or hundreds of cycles after the cause. For this reason the state of every core is compared on every cycle against a model, not only at the points the directed tests pick. A wrong field position or reserved bit in the status word or a configuration register shows up on the first read of that offset.

// File: rtl/pstate_pkg.sv
package pstate_pkg;
  localparam int unsigned PS_NUM_STATES   = 7;
  localparam int unsigned PS_MAX_STATE    = 6;
  localparam int unsigned PS_STATE_W      = 3;
  localparam int unsigned PS_FREQ_W       = 6;
  localparam int unsigned PS_LOCK_W       = 8;
  localparam int unsigned PS_FIELD_STRIDE = 4;
  localparam int unsigned PS_CFG_BASE     = 32'h0100;
  localparam int unsigned PS_CFG_STRIDE   = 32'h0010;
  localparam int unsigned PS_TIMING_OFS   = 32'h0440;
  localparam int unsigned PS_STATUS_OFS   = 32'h0000;
  localparam int unsigned PS_REQ_OFS      = 32'h0100;
  localparam int unsigned PS_REQ_STRIDE   = 32'h1000;

  typedef logic [PS_STATE_W-1:0] pstate_t;
endpackage

// File: rtl/pstate_cfg_regs.sv
module pstate_cfg_regs
  import pstate_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [PS_FREQ_W-1:0] code_wdata,
  input  logic [PS_LOCK_W-1:0] lock_wdata,
  input  logic                 coarse_wdata,
  output logic [PS_LOCK_W-1:0] lock_cnt,
  output logic                 coarse,
  output logic [31:0]          rd_data
);
  localparam int unsigned PAD_W = 32 - PS_FREQ_W;
  localparam int unsigned GAP_W = 31 - PS_LOCK_W;

  logic [PS_NUM_STATES-1:0][31:0] state_rd;

  // one frequency-code register per state
  for (genvar s = 0; s < PS_NUM_STATES; s++) begin : gen_state
    logic                 hit;
    logic                 en;
    logic [PS_FREQ_W-1:0] code_q;
    logic [PS_FREQ_W-1:0] code_d;

    assign hit = (addr == ADDR_W'(PS_CFG_BASE + s * PS_CFG_STRIDE));
    assign en  = wr_en && hit;

    always_comb begin
      code_d = code_q;
      if (en) code_d = code_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  code_q <= '0;
      else if (en) code_q <= code_d;
    end

    assign state_rd[s] = hit ? {{PAD_W{1'b0}}, code_q} : 32'h0;
  end

  // lock timing register
  logic                 tim_hit;
  logic                 tim_en;
  logic [PS_LOCK_W-1:0] lock_q, lock_d;
  logic                 coarse_q, coarse_d;

  assign tim_hit = (addr == ADDR_W'(PS_TIMING_OFS));
  assign tim_en  = wr_en && tim_hit;

  always_comb begin
    lock_d   = lock_q;
    coarse_d = coarse_q;
    if (tim_en) begin
      lock_d   = lock_wdata;
      coarse_d = coarse_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= '0;
      coarse_q <= 1'b0;
    end else if (tim_en) begin
      lock_q   <= lock_d;
      coarse_q <= coarse_d;
    end
  end

  assign lock_cnt = lock_q;
  assign coarse   = coarse_q;

  always_comb begin
    rd_data = 32'h0;
    for (int s = 0; s < PS_NUM_STATES; s++) rd_data |= state_rd[s];
    if (tim_hit) rd_data = {coarse_q, {GAP_W{1'b0}}, lock_q};
  end

  // R3
  timing_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tim_en |=> (lock_q == $past(lock_wdata)) && (coarse_q == $past(coarse_wdata)));
endmodule

// File: rtl/pstate_core_seq.sv
module pstate_core_seq
  import pstate_pkg::*;
#(
  parameter int unsigned DLY_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_en,
  input  logic [31:0]      req_word,
  input  logic [DLY_W-1:0] dly_load,
  input  logic             wake,
  output pstate_t          cur_state
);
  pstate_t          cur_q, cur_d;
  pstate_t          tgt_q, tgt_d;
  logic             pend_q, pend_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             req_ok;

  assign req_ok = req_en && (req_word <= 32'(PS_MAX_STATE));

  always_comb begin
    cur_d  = cur_q;
    tgt_d  = tgt_q;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (pend_q) begin
      if (cnt_q == '0) begin
        cur_d  = tgt_q;
        pend_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    if (wake) begin
      cur_d  = '0;
      pend_d = 1'b0;
    end
    if (req_ok) begin
      tgt_d  = pstate_t'(req_word[PS_STATE_W-1:0]);
      pend_d = 1'b1;
      cnt_d  = dly_load;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      tgt_q  <= '0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cur_q  <= cur_d;
      tgt_q  <= tgt_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cur_state = cur_q;

  // R5
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !wake) |=> $stable(cur_q));

  // R5
  state_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q <= pstate_t'(PS_MAX_STATE));

  // R6
  bad_req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en && (req_word > 32'(PS_MAX_STATE)) && !pend_q && !wake) |=> ($stable(cur_q) && !pend_q));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ok |=> (pend_q && (tgt_q == $past(req_word[PS_STATE_W-1:0])) && (cnt_q == $past(dly_load))));

  // R8
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !req_ok) |=> ((cur_q == '0) && !pend_q));
endmodule

// File: rtl/pstate_ctrl.sv
module pstate_ctrl
  import pstate_pkg::*;
#(
  parameter int unsigned NUM_CORES   = 2,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned COARSE_MULT = 128
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_valid,
  input  logic                            bus_write,
  input  logic                            bus_space,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [31:0]                     bus_wdata,
  output logic [31:0]                     bus_rdata,
  input  logic [NUM_CORES-1:0]            core_wake,
  output logic [NUM_CORES*PS_STATE_W-1:0] core_state
);
  localparam int unsigned MULT_W = (COARSE_MULT > 1) ? $clog2(COARSE_MULT) : 1;
  localparam int unsigned DLY_W  = PS_LOCK_W + MULT_W;

  logic                 cfg_wr;
  logic [PS_LOCK_W-1:0] lock_cnt;
  logic                 coarse;
  logic [31:0]          cfg_rd;
  logic [DLY_W-1:0]     dly_cycles;
  logic [DLY_W-1:0]     dly_load;
  logic [NUM_CORES-1:0] req_hit;
  logic [NUM_CORES-1:0][PS_STATE_W-1:0] cur_states;

  assign cfg_wr = bus_valid && bus_write && !bus_space;

  pstate_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (cfg_wr),
    .addr         (bus_addr),
    .code_wdata   (bus_wdata[PS_FREQ_W-1:0]),
    .lock_wdata   (bus_wdata[PS_LOCK_W-1:0]),
    .coarse_wdata (bus_wdata[31]),
    .lock_cnt     (lock_cnt),
    .coarse       (coarse),
    .rd_data      (cfg_rd)
  );

  // delay in clocks, minus one for the countdown
  always_comb begin
    if (coarse) dly_cycles = DLY_W'(lock_cnt) * DLY_W'(COARSE_MULT);
    else        dly_cycles = DLY_W'(lock_cnt);
    dly_load = (dly_cycles == '0) ? '0 : dly_cycles - 1'b1;
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : gen_core
    assign req_hit[c] = bus_valid && bus_write && bus_space &&
                        (bus_addr == ADDR_W'(PS_REQ_OFS + c * PS_REQ_STRIDE));

    pstate_core_seq #(.DLY_W(DLY_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_en    (req_hit[c]),
      .req_word  (bus_wdata),
      .dly_load  (dly_load),
      .wake      (core_wake[c]),
      .cur_state (cur_states[c])
    );
  end

  assign core_state = cur_states;

  // packed status word and read path
  logic [31:0] status_word;
  logic        status_hit;
  logic [31:0] rd_mux;
  logic        rd_en;
  logic [31:0] rdata_q, rdata_d;

  always_comb begin
    status_word = 32'h0;
    for (int c = 0; c < NUM_CORES; c++)
      status_word[c*PS_FIELD_STRIDE +: PS_STATE_W] = cur_states[c];
  end

  assign status_hit = !bus_space && (bus_addr == ADDR_W'(PS_STATUS_OFS));

  always_comb begin
    if (bus_space)       rd_mux = 32'h0;
    else if (status_hit) rd_mux = status_word;
    else                 rd_mux = cfg_rd;
  end

  assign rd_en = bus_valid && !bus_write;

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) rdata_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= 32'h0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  // R9
  req_space_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_space) |=> (bus_rdata == 32'h0));

  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> $stable(bus_rdata));
endmodule

// File: tb/pstate_ctrl_tb.sv
module pstate_ctrl_tb;
  localparam int NC = 2;
  localparam int AW = 16;
  localparam int CM = 128;

  logic            clk;
  logic            rst_n;
  logic            bus_valid;
  logic            bus_write;
  logic            bus_space;
  logic [AW-1:0]   bus_addr;
  logic [31:0]     bus_wdata;
  logic [31:0]     bus_rdata;
  logic [NC-1:0]   core_wake;
  logic [NC*3-1:0] core_state;

  pstate_ctrl #(.NUM_CORES(NC), .ADDR_W(AW), .COARSE_MULT(CM)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_space(bus_space), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .core_wake(core_wake), .core_state(core_state)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit track_on = 1'b0;
  bit done = 1'b0;

  // reference model
  int m_cur [NC];
  int m_tgt [NC];
  int m_rem [NC];
  bit m_pend[NC];
  int m_code[7];
  int m_lock;
  bit m_coarse;

  function automatic int delay_of(int lock, bit crs);
    int d;
    d = crs ? lock * CM : lock;
    return (d == 0) ? 1 : d;
  endfunction

  function automatic logic [31:0] status_exp();
    logic [31:0] w;
    w = 32'h0;
    for (int c = 0; c < NC; c++) w[c*4 +: 3] = 3'(m_cur[c]);
    return w;
  endfunction

  function automatic logic [31:0] cfg_exp(logic [15:0] a);
    if (a == 16'h0000) return status_exp();
    if (a == 16'h0440) return {m_coarse, 23'h0, 8'(m_lock)};
    for (int s = 0; s < 7; s++)
      if (a == 16'(32'h100 + s * 16)) return 32'(m_code[s]);
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin
        m_cur[c] = 0; m_tgt[c] = 0; m_rem[c] = 0; m_pend[c] = 1'b0;
      end
      for (int s = 0; s < 7; s++) m_code[s] = 0;
      m_lock = 0;
      m_coarse = 1'b0;
    end else begin
      for (int c = 0; c < NC; c++) begin
        if (m_pend[c]) begin
          m_rem[c] = m_rem[c] - 1;
          if (m_rem[c] == 0) begin
            m_cur[c] = m_tgt[c];
            m_pend[c] = 1'b0;
          end
        end
        if (core_wake[c]) begin
          m_cur[c] = 0;
          m_pend[c] = 1'b0;
        end
        if (bus_valid && bus_write && bus_space &&
            bus_addr == 16'(32'h100 + c * 32'h1000) && bus_wdata <= 32'd6) begin
          m_pend[c] = 1'b1;
          m_tgt[c] = int'(bus_wdata);
          m_rem[c] = delay_of(m_lock, m_coarse);
        end
      end
      if (bus_valid && bus_write && !bus_space) begin
        for (int s = 0; s < 7; s++)
          if (bus_addr == 16'(32'h100 + s * 16)) m_code[s] = int'(bus_wdata[5:0]);
        if (bus_addr == 16'h0440) begin
          m_lock = int'(bus_wdata[7:0]);
          m_coarse = bus_wdata[31];
        end
      end
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // every cycle: each core state against the model (R5 R7 R8 R10)
  always @(negedge clk) begin
    if (rst_n && track_on && !done)
      for (int c = 0; c < NC; c++)
        check(int'(core_state[c*3 +: 3]) == m_cur[c], "R5/R7/R8/R10 core_state tracking",
              core_state[c*3 +: 3], m_cur[c]);
  end

  task automatic bus_wr(bit sp, logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_space = sp; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(bit sp, logic [15:0] a, output logic [31:0] d, output logic [31:0] e);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_space = sp; bus_addr = a;
    e = sp ? 32'h0 : cfg_exp(a);
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_wake(int c);
    @(negedge clk);
    core_wake[c] = 1'b1;
    @(negedge clk);
    core_wake[c] = 1'b0;
  endtask

  function automatic logic [15:0] req_addr(int c);
    return 16'(32'h100 + c * 32'h1000);
  endfunction

  function automatic logic [2:0] st(int c);
    return core_state[c*3 +: 3];
  endfunction

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, ex, w;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    bus_valid = 1'b0; bus_write = 1'b0; bus_space = 1'b0;
    bus_addr = '0; bus_wdata = '0; core_wake = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    track_on = 1'b1;

    // R1 reset state
    check(core_state == '0, "R1 core_state after reset", core_state, 0);
    check(bus_rdata == 32'h0, "R1 rdata after reset", bus_rdata, 0);
    bus_rd(1'b0, 16'h0000, rd, ex);
    check(rd == 32'h0, "R1 status after reset", rd, 0);
    bus_rd(1'b0, 16'h0440, rd, ex);
    check(rd == 32'h0, "R1 timing after reset", rd, 0);
    bus_rd(1'b0, 16'h0130, rd, ex);
    check(rd == 32'h0, "R1 freq code after reset", rd, 0);

    // R2 frequency codes incl. turbo states
    for (int s = 0; s < 7; s++) begin
      w = $urandom();
      bus_wr(1'b0, 16'(32'h100 + s * 16), w);
      bus_rd(1'b0, 16'(32'h100 + s * 16), rd, ex);
      check(rd == {26'h0, w[5:0]}, "R2 freq code readback", rd, {26'h0, w[5:0]});
    end

    // R3 timing register fields
    bus_wr(1'b0, 16'h0440, 32'hFFFF_FF05);
    bus_rd(1'b0, 16'h0440, rd, ex);
    check(rd == 32'h8000_0005, "R3 timing fields", rd, 32'h8000_0005);
    repeat (3) @(negedge clk);
    check(bus_rdata == 32'h8000_0005, "R3 rdata holds", bus_rdata, 32'h8000_0005);
    bus_wr(1'b0, 16'h0440, 32'h0);

    // R4 status read-only, R9 unmapped
    bus_wr(1'b0, 16'h0000, 32'hFFFF_FFFF);
    bus_rd(1'b0, 16'h0000, rd, ex);
    check(rd == 32'h0, "R4 status ignores write", rd, 0);
    bus_wr(1'b0, 16'h0204, 32'hFFFF_FFFF);
    bus_rd(1'b0, 16'h0204, rd, ex);
    check(rd == 32'h0, "R9 unmapped reads zero", rd, 0);
    bus_rd(1'b1, req_addr(0), rd, ex);
    check(rd == 32'h0, "R9 request space reads zero", rd, 0);
    check(core_state == '0, "R9 unmapped write no effect on state", core_state, 0);

    // R5 zero count: one cycle
    bus_wr(1'b1, req_addr(0), 32'd3);
    check(st(0) == 3'd0, "R5 old state on accept edge", st(0), 0);
    @(negedge clk);
    check(st(0) == 3'd3, "R5 commit after 1 cycle", st(0), 3);

    // R5 fine count 5, turbo target on core 1 (R10 core 0 unaffected)
    bus_wr(1'b0, 16'h0440, 32'd5);
    bus_wr(1'b1, req_addr(1), 32'd6);
    for (int i = 1; i < 5; i++) begin
      @(negedge clk);
      check(st(1) == 3'd0, "R5 hold during fine delay", st(1), 0);
    end
    @(negedge clk);
    check(st(1) == 3'd6, "R5 commit after 5 cycles", st(1), 6);
    check(st(0) == 3'd3, "R10 other core unchanged", st(0), 3);

    // R5 coarse count 2 -> 256 cycles
    bus_wr(1'b0, 16'h0440, 32'h8000_0002);
    bus_wr(1'b1, req_addr(0), 32'd1);
    repeat (255) @(negedge clk);
    check(st(0) == 3'd3, "R5 hold during coarse delay", st(0), 3);
    @(negedge clk);
    check(st(0) == 3'd1, "R5 commit after 256 cycles", st(0), 1);

    // R6 out-of-range requests
    bus_wr(1'b0, 16'h0440, 32'd0);
    bus_wr(1'b1, req_addr(1), 32'd7);
    bus_wr(1'b1, req_addr(1), 32'h10);
    bus_wr(1'b1, req_addr(1), 32'hFFFF_FFFE);
    repeat (5) @(negedge clk);
    check(st(1) == 3'd6, "R6 illegal request ignored", st(1), 6);
    bus_wr(1'b0, 16'h0440, 32'd8);
    bus_wr(1'b1, req_addr(1), 32'd2);
    bus_wr(1'b1, req_addr(1), 32'd7);
    repeat (6) @(negedge clk);
    check(st(1) == 3'd2, "R6 illegal request keeps pending", st(1), 2);

    // R7 restart during pending
    bus_wr(1'b0, 16'h0440, 32'd20);
    bus_wr(1'b1, req_addr(0), 32'd4);
    repeat (10) @(negedge clk);
    bus_wr(1'b1, req_addr(0), 32'd5);
    repeat (19) @(negedge clk);
    check(st(0) == 3'd1, "R7 old state held after restart", st(0), 1);
    @(negedge clk);
    check(st(0) == 3'd5, "R7 new target after full delay", st(0), 5);

    // R8 wake cancels pending; R10 other core untouched
    bus_wr(1'b0, 16'h0440, 32'd50);
    bus_wr(1'b1, req_addr(1), 32'd4);
    repeat (5) @(negedge clk);
    pulse_wake(1);
    check(st(1) == 3'd0, "R8 wake forces state 0", st(1), 0);
    repeat (60) @(negedge clk);
    check(st(1) == 3'd0, "R8 pending cancelled by wake", st(1), 0);
    check(st(0) == 3'd5, "R10 wake on other core", st(0), 5);

    // R8 wake together with request
    bus_wr(1'b0, 16'h0440, 32'd3);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_space = 1'b1;
    bus_addr = req_addr(0); bus_wdata = 32'd2; core_wake[0] = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; core_wake[0] = 1'b0;
    check(st(0) == 3'd0, "R8 wake with request gives 0", st(0), 0);
    repeat (3) @(negedge clk);
    check(st(0) == 3'd2, "R8 simultaneous request still commits", st(0), 2);

    // R4 packed status
    bus_wr(1'b0, 16'h0440, 32'd0);
    bus_wr(1'b1, req_addr(0), 32'd3);
    bus_wr(1'b1, req_addr(1), 32'd5);
    repeat (2) @(negedge clk);
    bus_rd(1'b0, 16'h0000, rd, ex);
    check(rd == 32'h0000_0053, "R4 packed status word", rd, 32'h53);

    // random mix against the model
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(9);
      case (op)
        0: begin
          int lk; bit cr;
          cr = ($urandom_range(7) == 0);
          lk = cr ? $urandom_range(1) : $urandom_range(12);
          bus_wr(1'b0, 16'h0440, {cr, 23'($urandom()), 8'(lk)});
        end
        1: bus_wr(1'b0, 16'(32'h100 + $urandom_range(6) * 16), $urandom());
        2, 3, 4: bus_wr(1'b1, req_addr($urandom_range(NC-1)), 32'($urandom_range(8)));
        5: pulse_wake($urandom_range(NC-1));
        6, 7: begin
          bus_rd(1'b0, 16'h0000, rd, ex);
          check(rd == ex, "R4 random status read", rd, ex);
        end
        8: begin
          logic [15:0] a;
          a = ($urandom_range(1) == 0) ? 16'h0440 : 16'(32'h100 + $urandom_range(7) * 16);
          bus_rd(1'b0, a, rd, ex);
          check(rd == ex, "R2/R3 random config read", rd, ex);
        end
        default: repeat ($urandom_range(20)) @(negedge clk);
      endcase
    end
    repeat (300) @(negedge clk);
    bus_rd(1'b0, 16'h0000, rd, ex);
    check(rd == ex, "R4 final status", rd, ex);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule